// File: doc/BRIEF.md
# Virtual-Channel Data-Type Stream Classifier

This block sorts camera-link packet headers into channel identifiers. Every header carries a small virtual-channel number and a 6-bit data type. For each virtual channel the block holds one lookup word made of four 8-bit slots. It searches that word for the header's data type. A match at slot k of channel v gives identifier v*4+k. Each identifier has its own configuration word. That word decides which output paths accept the packet and which decode attributes travel with it.

Software fills the lookup words and configuration words through a simple write port. The header side is one strobe with its channel and data type. One clock after the strobe, the block presents the identifier, hit and miss flags, single-cycle path strobes and the decode attributes. These outputs then stay unchanged until the next header. Configuration written while a packet is in flight therefore applies only from the following header.

Top module: `stream_cid_classifier`

## Requirements
- R1: After reset all outputs are 0, and every lookup and configuration word is 0. A header with a nonzero data type then misses. A header with data type 0 hits slot 0 of its channel, but raises no path strobe.
- R2: Slot k of a lookup word is bits [8k+7:8k]. A slot matches only when it equals the data type padded with two zero bits on top. The identifier for a match is channel*4 + k.
- R3: When several slots of one lookup word match, the lowest slot index sets the identifier.
- R4: A header that matches no slot sets miss_o, clears hit_o, raises no path strobe, and drives the identifier and all attributes to 0.
- R5: Bit 0 of the matched configuration word enables a one-cycle pulse on main_vld_o. Bit 1 enables a one-cycle pulse on raw_vld_o. The pulses appear in the cycle after the header strobe.
- R6: The matched configuration word supplies the attributes. The decode format is bits [7:4]. Bit 8 selects 16-bit plain words, bit 9 selects MSB alignment, and bit 10 selects plain packing (0 means raw dump).
- R7: The results are registered at the clock edge that samples hdr_vld_i. Without a new header, the identifier, flags and attributes hold their values and both path strobes stay low.
- R8: A table write takes effect only at a later header. A write in the same cycle as a header does not affect that header's result, and a write between headers leaves the presented outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_vld_i | input | 1 | Header strobe, one cycle per packet |
| hdr_vc_i | input | 2 | Virtual channel of the header |
| hdr_dt_i | input | 6 | Data type of the header |
| wr_lut_i | input | 1 | Write a lookup word |
| wr_cfg_i | input | 1 | Write an identifier configuration word |
| wr_index_i | input | 4 | Channel (lookup) or identifier (configuration) to write |
| wr_data_i | input | 32 | Write data; configuration uses bits [10:0] |
| cid_o | output | 4 | Matched identifier |
| hit_o | output | 1 | Last header matched a slot |
| miss_o | output | 1 | Last header matched no slot |
| main_vld_o | output | 1 | Pulse: packet accepted on the main path |
| raw_vld_o | output | 1 | Pulse: packet accepted on the raw-dump path |
| fmt_o | output | 4 | Decode-format code |
| plain16_o | output | 1 | 16-bit plain words selected |
| align_msb_o | output | 1 | MSB alignment selected |
| packing_o | output | 1 | Plain packing selected |

## Verification
The checker assumes hdr_vld_i is a clean single-cycle strobe, and that hdr_vc_i and hdr_dt_i are valid whenever it is high. The checker also assumes that hdr_vld_i is low when reset is released, so that no past value reaches back before reset. The stimulus drives every input at the falling edge. It holds all inputs at 0 during reset, sends headers only with defined channel and data-type values, and sends back-to-back headers only as full one-cycle strobes. Writes are sent alone, or together with a header in the one case that tests write-versus-header ordering.

// File: rtl/vcdt_pkg.sv
package vcdt_pkg;
    localparam int SLOT_W = 8;
    localparam int DT_W   = 6;
    localparam int CFG_W  = 11;

    // Configuration word of one identifier, bit 0 at the bottom
    typedef struct packed {
        logic       packing;    // bit 10
        logic       align_msb;  // bit 9
        logic       plain16;    // bit 8
        logic [3:0] fmt;        // bits 7:4
        logic [1:0] spare;      // bits 3:2
        logic       raw_en;     // bit 1
        logic       main_en;    // bit 0
    } cid_cfg_t;
endpackage

// File: rtl/vcdt_table_store.sv
module vcdt_table_store
    import vcdt_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int SLOTS  = 4,
    localparam int LUT_W = SLOTS * SLOT_W,
    localparam int NCID  = NUM_VC * SLOTS,
    localparam int VC_W  = $clog2(NUM_VC),
    localparam int CID_W = $clog2(NCID)
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              wr_lut_i,
    input  logic                              wr_cfg_i,
    input  logic [CID_W-1:0]                  wr_index_i,
    input  logic [LUT_W-1:0]                  wr_data_i,
    output logic [NUM_VC-1:0][LUT_W-1:0]      lut_o,
    output cid_cfg_t [NCID-1:0]               cfg_o
);
    typedef struct packed {
        logic [NUM_VC-1:0][LUT_W-1:0] lut;
        cid_cfg_t [NCID-1:0]          cfg;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lut_i && (int'(wr_index_i) < NUM_VC)) begin
            st_d.lut[wr_index_i[VC_W-1:0]] = wr_data_i;
        end
        if (wr_cfg_i) begin
            st_d.cfg[wr_index_i] = cid_cfg_t'(wr_data_i[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lut_o = st_q.lut;
    assign cfg_o = st_q.cfg;
endmodule

// File: rtl/vcdt_slot_match.sv
module vcdt_slot_match
    import vcdt_pkg::*;
#(
    parameter int SLOTS  = 4,
    localparam int LUT_W = SLOTS * SLOT_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [LUT_W-1:0] lut_word_i,
    input  logic [DT_W-1:0]  dt_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] slot_o
);
    logic [SLOTS-1:0] eq;
    logic [SLOT_W-1:0] key;

    assign key = {{(SLOT_W-DT_W){1'b0}}, dt_i};

    for (genvar k = 0; k < SLOTS; k++) begin : g_cmp
        assign eq[k] = (lut_word_i[k*SLOT_W +: SLOT_W] == key);
    end

    // Scan from the top so the lowest matching slot is the one kept
    always_comb begin
        slot_o = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (eq[k]) slot_o = IDX_W'(k);
        end
        hit_o = |eq;
    end
endmodule

// File: rtl/stream_cid_classifier.sv
module stream_cid_classifier
    import vcdt_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int SLOTS  = 4,
    localparam int LUT_W = SLOTS * SLOT_W,
    localparam int NCID  = NUM_VC * SLOTS,
    localparam int VC_W  = $clog2(NUM_VC),
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CID_W = VC_W + IDX_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hdr_vld_i,
    input  logic [VC_W-1:0]  hdr_vc_i,
    input  logic [DT_W-1:0]  hdr_dt_i,
    input  logic             wr_lut_i,
    input  logic             wr_cfg_i,
    input  logic [CID_W-1:0] wr_index_i,
    input  logic [LUT_W-1:0] wr_data_i,
    output logic [CID_W-1:0] cid_o,
    output logic             hit_o,
    output logic             miss_o,
    output logic             main_vld_o,
    output logic             raw_vld_o,
    output logic [3:0]       fmt_o,
    output logic             plain16_o,
    output logic             align_msb_o,
    output logic             packing_o
);
    typedef struct packed {
        logic [CID_W-1:0] cid;
        logic             hit;
        logic             miss;
        logic             main_vld;
        logic             raw_vld;
        logic [3:0]       fmt;
        logic             plain16;
        logic             align_msb;
        logic             packing;
    } res_t;

    logic [NUM_VC-1:0][LUT_W-1:0] lut_all;
    cid_cfg_t [NCID-1:0]          cfg_all;
    logic                         slot_hit;
    logic [IDX_W-1:0]             slot_idx;
    logic [CID_W-1:0]             cid_sel;
    cid_cfg_t                     cfg_sel;
    res_t                         res_d, res_q;

    vcdt_table_store #(
        .NUM_VC (NUM_VC),
        .SLOTS  (SLOTS)
    ) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_lut_i   (wr_lut_i),
        .wr_cfg_i   (wr_cfg_i),
        .wr_index_i (wr_index_i),
        .wr_data_i  (wr_data_i),
        .lut_o      (lut_all),
        .cfg_o      (cfg_all)
    );

    vcdt_slot_match #(
        .SLOTS (SLOTS)
    ) u_match (
        .lut_word_i (lut_all[hdr_vc_i]),
        .dt_i       (hdr_dt_i),
        .hit_o      (slot_hit),
        .slot_o     (slot_idx)
    );

    assign cid_sel = {hdr_vc_i, slot_idx};
    assign cfg_sel = cfg_all[cid_sel];

    always_comb begin
        res_d          = res_q;
        res_d.main_vld = 1'b0;
        res_d.raw_vld  = 1'b0;
        if (hdr_vld_i) begin
            if (slot_hit) begin
                res_d.cid       = cid_sel;
                res_d.hit       = 1'b1;
                res_d.miss      = 1'b0;
                res_d.main_vld  = cfg_sel.main_en;
                res_d.raw_vld   = cfg_sel.raw_en;
                res_d.fmt       = cfg_sel.fmt;
                res_d.plain16   = cfg_sel.plain16;
                res_d.align_msb = cfg_sel.align_msb;
                res_d.packing   = cfg_sel.packing;
            end else begin
                res_d      = '0;
                res_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign cid_o       = res_q.cid;
    assign hit_o       = res_q.hit;
    assign miss_o      = res_q.miss;
    assign main_vld_o  = res_q.main_vld;
    assign raw_vld_o   = res_q.raw_vld;
    assign fmt_o       = res_q.fmt;
    assign plain16_o   = res_q.plain16;
    assign align_msb_o = res_q.align_msb;
    assign packing_o   = res_q.packing;
endmodule

// File: rtl/vcdt_checker.sv
module vcdt_checker #(
    parameter int VC_W  = 2,
    parameter int CID_W = 4,
    parameter int DT_W  = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             hdr_vld_i,
    input logic [VC_W-1:0]  hdr_vc_i,
    input logic [CID_W-1:0] cid_o,
    input logic             hit_o,
    input logic             miss_o,
    input logic             main_vld_o,
    input logic             raw_vld_o,
    input logic [3:0]       fmt_o
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_o && miss_o)); // R4

    AST_HDR_GIVES_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hdr_vld_i |=> (hit_o != miss_o)); // R7

    AST_STROBE_AFTER_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (main_vld_o || raw_vld_o) |-> $past(hdr_vld_i)); // R5

    AST_MISS_NO_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_o |-> (!main_vld_o && !raw_vld_o && cid_o == '0 && fmt_o == '0)); // R4

    AST_CID_CARRIES_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hdr_vld_i) |=> (!hit_o || cid_o[CID_W-1 -: VC_W] == $past(hdr_vc_i))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hdr_vld_i |=> ($stable(cid_o) && $stable(hit_o) && $stable(fmt_o)
                        && !main_vld_o && !raw_vld_o)); // R8
endmodule

bind stream_cid_classifier vcdt_checker #(
    .VC_W  (VC_W),
    .CID_W (CID_W),
    .DT_W  (vcdt_pkg::DT_W)
) u_vcdt_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hdr_vld_i  (hdr_vld_i),
    .hdr_vc_i   (hdr_vc_i),
    .cid_o      (cid_o),
    .hit_o      (hit_o),
    .miss_o     (miss_o),
    .main_vld_o (main_vld_o),
    .raw_vld_o  (raw_vld_o),
    .fmt_o      (fmt_o)
);

// File: tb/stream_cid_classifier_test.sv
`timescale 1ns/1ps
module stream_cid_classifier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_vld = 1'b0;
    logic [1:0]  hdr_vc = '0;
    logic [5:0]  hdr_dt = '0;
    logic        wr_lut = 1'b0;
    logic        wr_cfg = 1'b0;
    logic [3:0]  wr_index = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  cid;
    logic        hit, miss, main_vld, raw_vld, plain16, align_msb, packing;
    logic [3:0]  fmt;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    always #5 clk = ~clk;

    stream_cid_classifier uut (
        .clk_i(clk), .rst_ni(rst_n), .hdr_vld_i(hdr_vld), .hdr_vc_i(hdr_vc),
        .hdr_dt_i(hdr_dt), .wr_lut_i(wr_lut), .wr_cfg_i(wr_cfg),
        .wr_index_i(wr_index), .wr_data_i(wr_data), .cid_o(cid), .hit_o(hit),
        .miss_o(miss), .main_vld_o(main_vld), .raw_vld_o(raw_vld), .fmt_o(fmt),
        .plain16_o(plain16), .align_msb_o(align_msb), .packing_o(packing)
    );

    // Reference tables built from the requirements
    logic [31:0] m_lut [4];
    logic [10:0] m_cfg [16];

    typedef struct {
        logic [3:0] cid;
        logic       hit, miss, mv, rv, p16, am, pk;
        logic [3:0] fmt;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t last;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [1:0] vc, input logic [5:0] dt,
                                     input string req);
        exp_t e;
        int found = -1;
        e = '{cid:0, hit:0, miss:1, mv:0, rv:0, p16:0, am:0, pk:0, fmt:0, req:req};
        for (int k = 3; k >= 0; k--) begin
            if (m_lut[vc][8*k +: 8] == {2'b00, dt}) found = k;
        end
        if (found >= 0) begin
            logic [10:0] c;
            e.cid  = 4'(vc * 4 + found);
            c      = m_cfg[e.cid];
            e.hit  = 1; e.miss = 0;
            e.mv   = c[0]; e.rv = c[1]; e.fmt = c[7:4];
            e.p16  = c[8]; e.am = c[9]; e.pk = c[10];
        end
        return e;
    endfunction

    // All driver tasks are entered at a falling edge
    task automatic send_hdr(input logic [1:0] vc, input logic [5:0] dt, input string req);
        q.push_back(predict(vc, dt, req));
        hdr_vld = 1; hdr_vc = vc; hdr_dt = dt;
        @(negedge clk);
        hdr_vld = 0;
    endtask

    task automatic put_lut(input logic [3:0] idx, input logic [31:0] d);
        if (idx < 4) m_lut[idx[1:0]] = d;
        wr_lut = 1; wr_index = idx; wr_data = d;
        @(negedge clk);
        wr_lut = 0;
    endtask

    task automatic put_cfg(input logic [3:0] idx, input logic [10:0] d);
        m_cfg[idx] = d;
        wr_cfg = 1; wr_index = idx; wr_data = {21'd0, d};
        @(negedge clk);
        wr_cfg = 0;
    endtask

    task automatic hdr_with_cfg(input logic [1:0] vc, input logic [5:0] dt,
                                input logic [3:0] idx, input logic [10:0] d);
        q.push_back(predict(vc, dt, "R8"));
        m_cfg[idx] = d;
        hdr_vld = 1; hdr_vc = vc; hdr_dt = dt;
        wr_cfg = 1; wr_index = idx; wr_data = {21'd0, d};
        @(negedge clk);
        hdr_vld = 0; wr_cfg = 0;
    endtask

    // Monitor: compares each result one cycle after its header; checks holding otherwise
    initial begin
        last = '{cid:0, hit:0, miss:0, mv:0, rv:0, p16:0, am:0, pk:0, fmt:0, req:"R7"};
        forever begin
            @(posedge clk);
            if (started && hdr_vld) begin
                exp_t e;
                @(negedge clk);
                if (q.size() == 0) begin
                    chk("R7", "unexpected result", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(e.req, "cid", cid, e.cid);
                    chk(e.req, "hit", hit, e.hit);
                    chk(e.req, "miss", miss, e.miss);
                    chk(e.req, "main_vld", main_vld, e.mv);
                    chk(e.req, "raw_vld", raw_vld, e.rv);
                    chk(e.req, "fmt", fmt, e.fmt);
                    chk(e.req, "plain16", plain16, e.p16);
                    chk(e.req, "align_msb", align_msb, e.am);
                    chk(e.req, "packing", packing, e.pk);
                    last = e;
                end
            end else if (started) begin
                @(negedge clk);
                // R7 and R8: outputs hold, strobes low between headers
                chk("R7", "idle strobes", {main_vld, raw_vld}, 0);
                chk("R8", "held cid/hit/fmt", {cid, hit, miss, fmt},
                    {last.cid, last.hit, last.miss, last.fmt});
            end
        end
    end

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < 4; i++) m_lut[i] = '0;
        for (int i = 0; i < 16; i++) m_cfg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state of outputs
        chk("R1", "outputs after reset",
            {cid, hit, miss, main_vld, raw_vld, fmt, plain16, align_msb, packing}, 0);
        started = 1;

        send_hdr(2'd2, 6'h2B, "R1");          // cleared table: miss
        send_hdr(2'd1, 6'h00, "R1");          // zero slot hits cid 4, no path
        repeat (2) @(negedge clk);

        // R2/R5/R6: one data type per slot, distinct configurations
        put_lut(4'd0, {8'h2C, 8'h2B, 8'h2A, 8'h1E});
        put_cfg(4'd0, 11'b0_0_0_0001_00_01);
        put_cfg(4'd1, 11'b0_0_1_0001_00_10);
        put_cfg(4'd2, 11'b1_1_0_0010_00_11);
        put_cfg(4'd3, 11'b0_1_1_0011_00_11);
        send_hdr(2'd0, 6'h1E, "R5");
        send_hdr(2'd0, 6'h2A, "R6");
        send_hdr(2'd0, 6'h2B, "R6");
        send_hdr(2'd0, 6'h2C, "R2");
        @(negedge clk);

        // R3: duplicate data type in slots 1 and 3
        put_lut(4'd3, {8'h2B, 8'h24, 8'h2B, 8'h07});
        put_cfg(4'd13, 11'b0_0_0_0101_00_01);
        put_cfg(4'd15, 11'b1_1_1_1111_00_11);
        send_hdr(2'd3, 6'h2B, "R3");
        send_hdr(2'd3, 6'h07, "R2");

        // R2: nonzero top bits in a slot never match
        put_lut(4'd2, {8'h11, 8'h12, 8'h13, 8'hEA});
        put_cfg(4'd11, 11'b0_1_0_0110_00_10);
        send_hdr(2'd2, 6'h2A, "R2");
        send_hdr(2'd2, 6'h11, "R2");

        // R4: miss right after a hit
        send_hdr(2'd0, 6'h1E, "R4");
        send_hdr(2'd1, 6'h2A, "R4");

        // R8: write between headers changes nothing until the next header
        send_hdr(2'd0, 6'h1E, "R8");
        put_cfg(4'd0, 11'b1_0_1_1001_00_10);
        repeat (3) @(negedge clk);
        send_hdr(2'd0, 6'h1E, "R8");

        // R8: write in the same cycle as the header is not seen by it
        hdr_with_cfg(2'd0, 6'h2A, 4'd1, 11'b1_1_1_0111_00_01);
        send_hdr(2'd0, 6'h2A, "R8");
        repeat (3) @(negedge clk);

        chk("R7", "all results consumed", q.size(), 0);
        report();
    end
endmodule